// File: doc/BRIEF.md
# I2C Target Front End with Conversion-Busy Refusal

This block is the two-wire serial target interface of a data-converter style peripheral. It oversamples the clock and data lines with a fast system clock, recognises Start, Repeated Start and Stop conditions, and decodes the address byte that follows every Start. Its own 7-bit address is picked by a 4-bit strap input out of nine consecutive values above a base address parameter.

A write transfer fills a small configuration register one byte at a time. When a Stop closes a transaction that stored at least one configuration byte, the block emits a single-cycle request to begin a conversion. A read transfer returns the peripheral's latest result, most significant byte first. While the peripheral reports that a conversion is running, the block refuses its own address with a NAK and stays silent until the next Start. The data line is only ever pulled low through an enable output. The board supplies the high level through a pull-up resistor.

Top module: `i2c_busy_target`

## Requirements
- R1: A falling data line while the clock line is high is a Start, and a rising data line while the clock line is high is a Stop. `bus_active` goes to 1 after a Start and returns to 0 after a Stop.
- R2: The first byte after any Start arrives MSB first. It holds the 7-bit address in bits 7..1 and the direction in bit 0, where 1 means read and 0 means write. The block acknowledges only when the address equals `ADDR_BASE + strap_sel`. The strap offers values 0..8, and any strap value above 8 acts as 8.
- R3: If the address matches while `busy` is 1, the block leaves the data line released on the acknowledge clock (NAK). It then drives nothing and stores nothing until the next Start.
- R4: An address that does not match is answered with a NAK, and the rest of that transaction is ignored.
- R5: In a write, data bytes arrive MSB first and are each acknowledged. The first byte lands in `cfg_out[15:8]` and the second in `cfg_out[7:0]`. Any byte beyond `CFG_BYTES` is NAKed and discarded.
- R6: In a read, the block sends the bytes of `result_in` starting from bits 23..16, MSB first. It moves to the next byte after each master ACK and wraps to the first byte after the last. After a master NAK it keeps the data line released until the next Start.
- R7: A Repeated Start abandons any partial byte and expects a new address byte. `bus_active` stays 1 across it.
- R8: `conv_start` is a one-cycle pulse, issued after the Stop of a transaction that stored at least one configuration byte. Reads, refused transfers and address-only writes give no pulse.
- R9: `sda_pull` changes only while the synchronised clock line is low. It is 0 whenever the bus is idle, and after reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 20 times the bus bit rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_pull | output | 1 | 1 pulls the data line low; 0 releases it |
| strap_sel | input | 4 | Address strap selection, 0..8 |
| busy | input | 1 | Conversion in progress; refuse own address |
| result_in | input | 24 | Latest conversion result to be read out |
| cfg_out | output | 16 | Configuration bytes received by writes |
| conv_start | output | 1 | One-cycle request to start a conversion |
| bus_active | output | 1 | Bus held between Start and Stop |

## Verification
The hardest situation to reach from the ports is a Repeated Start that lands in the middle of a data byte. The master has to raise the data line while the clock is low and then pull it low under a high clock, after only a few bits have been shifted in. The bench bit-bangs three data bits of a write and then issues the Repeated Start. It follows with a read address and checks that the first result byte comes back intact and that the Stop produces no conversion request. The busy refusal is reached by holding `busy` through an address phase whose address matches.

// File: rtl/i2c_bt_pkg.sv
package i2c_bt_pkg;

    localparam int NUM_ADDR = 9;
    localparam int BYTE_W   = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_WDATA,
        ST_WACK,
        ST_RDATA,
        ST_MACK,
        ST_IGNORE
    } eng_state_e;

    typedef struct packed {
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_evt_t;

    // Address chosen by the strap; values above the last option clamp to it.
    function automatic logic [6:0] strap_addr(input logic [6:0] base,
                                              input logic [3:0] sel);
        if (int'(sel) >= NUM_ADDR)
            return base + 7'(NUM_ADDR - 1);
        return base + {3'b000, sel};
    endfunction

endpackage

// File: rtl/i2c_bt_sync.sv
module i2c_bt_sync #(
    parameter int STAGES = 2,
    parameter int LINES  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] din,
    output logic [LINES-1:0] dout
);
    genvar g;
    generate
        for (g = 0; g < LINES; g++) begin : g_line
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[STAGES-2:0], din[g]};
            end
            assign dout[g] = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/i2c_bt_cond.sv
module i2c_bt_cond
    import i2c_bt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_s,
    input  logic     sda_s,
    output bus_evt_t evt
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    always_comb begin
        evt.sda      = sda_s;
        evt.scl_rise = !scl_q && scl_s;
        evt.scl_fall = scl_q && !scl_s;
        evt.start    = scl_q && scl_s && sda_q && !sda_s;
        evt.stop     = scl_q && scl_s && !sda_q && sda_s;
    end
endmodule

// File: rtl/i2c_bt_engine.sv
module i2c_bt_engine
    import i2c_bt_pkg::*;
#(
    parameter int CFG_BYTES = 2,
    parameter int RES_BYTES = 3
) (
    input  logic                        clk,
    input  logic                        rst,
    input  bus_evt_t                    evt,
    input  logic [6:0]                  my_addr,
    input  logic                        busy,
    input  logic [RES_BYTES*BYTE_W-1:0] result_in,
    output logic                        sda_pull,
    output logic [CFG_BYTES*BYTE_W-1:0] cfg_out,
    output logic                        conv_start,
    output logic                        bus_active,
    output eng_state_e                  state
);
    localparam int RIW = (RES_BYTES > 1) ? $clog2(RES_BYTES) : 1;
    localparam int CIW = $clog2(CFG_BYTES + 1);

    logic [3:0]        bitcnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] txreg;
    logic              rw_q;
    logic              mack_q;
    logic              wr_pend;
    logic [RIW-1:0]    rd_idx;
    logic [CIW-1:0]    cfg_idx;

    function automatic logic [BYTE_W-1:0] res_byte(input logic [RIW-1:0] idx);
        return result_in[(RES_BYTES-1-int'(idx))*BYTE_W +: BYTE_W];
    endfunction

    function automatic logic [RIW-1:0] next_idx(input logic [RIW-1:0] idx);
        if (int'(idx) == RES_BYTES - 1) return '0;
        return idx + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            bitcnt     <= '0;
            shreg      <= '0;
            txreg      <= '0;
            rw_q       <= 1'b0;
            mack_q     <= 1'b0;
            wr_pend    <= 1'b0;
            rd_idx     <= '0;
            cfg_idx    <= '0;
            cfg_out    <= '0;
            sda_pull   <= 1'b0;
            conv_start <= 1'b0;
            bus_active <= 1'b0;
        end else begin
            conv_start <= 1'b0;
            if (evt.stop) begin
                conv_start <= wr_pend;
                wr_pend    <= 1'b0;
                state      <= ST_IDLE;
                bus_active <= 1'b0;
                sda_pull   <= 1'b0;
            end else if (evt.start) begin
                state      <= ST_ADDR;
                bus_active <= 1'b1;
                bitcnt     <= '0;
                sda_pull   <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR, ST_WDATA: begin
                        if (evt.scl_rise) begin
                            shreg  <= {shreg[BYTE_W-2:0], evt.sda};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (evt.scl_fall && bitcnt == 4'd8) begin
                            bitcnt <= '0;
                            if (state == ST_ADDR) begin
                                if (shreg[7:1] == my_addr && !busy) begin
                                    rw_q     <= shreg[0];
                                    sda_pull <= 1'b1;
                                    state    <= ST_AACK;
                                end else begin
                                    state <= ST_IGNORE;
                                end
                            end else if (int'(cfg_idx) < CFG_BYTES) begin
                                cfg_out[(CFG_BYTES-1-int'(cfg_idx))*BYTE_W +: BYTE_W] <= shreg;
                                cfg_idx  <= cfg_idx + 1'b1;
                                wr_pend  <= 1'b1;
                                sda_pull <= 1'b1;
                                state    <= ST_WACK;
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end
                    end
                    ST_AACK: begin
                        if (evt.scl_fall) begin
                            bitcnt <= '0;
                            if (rw_q) begin
                                rd_idx   <= '0;
                                txreg    <= res_byte('0);
                                sda_pull <= !res_byte('0)[BYTE_W-1];
                                state    <= ST_RDATA;
                            end else begin
                                cfg_idx  <= '0;
                                sda_pull <= 1'b0;
                                state    <= ST_WDATA;
                            end
                        end
                    end
                    ST_WACK: begin
                        if (evt.scl_fall) begin
                            sda_pull <= 1'b0;
                            state    <= ST_WDATA;
                        end
                    end
                    ST_RDATA: begin
                        if (evt.scl_fall) begin
                            if (bitcnt == 4'd7) begin
                                sda_pull <= 1'b0;
                                state    <= ST_MACK;
                            end else begin
                                txreg    <= {txreg[BYTE_W-2:0], 1'b0};
                                sda_pull <= !txreg[BYTE_W-2];
                                bitcnt   <= bitcnt + 4'd1;
                            end
                        end
                    end
                    ST_MACK: begin
                        if (evt.scl_rise) begin
                            mack_q <= !evt.sda;
                        end else if (evt.scl_fall) begin
                            bitcnt <= '0;
                            if (mack_q) begin
                                rd_idx   <= next_idx(rd_idx);
                                txreg    <= res_byte(next_idx(rd_idx));
                                sda_pull <= !res_byte(next_idx(rd_idx))[BYTE_W-1];
                                state    <= ST_RDATA;
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_busy_target.sv
module i2c_busy_target
    import i2c_bt_pkg::*;
#(
    parameter logic [6:0] ADDR_BASE   = 7'h24,
    parameter int         CFG_BYTES   = 2,
    parameter int         RES_BYTES   = 3,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        scl_in,
    input  logic                        sda_in,
    output logic                        sda_pull,
    input  logic [3:0]                  strap_sel,
    input  logic                        busy,
    input  logic [RES_BYTES*BYTE_W-1:0] result_in,
    output logic [CFG_BYTES*BYTE_W-1:0] cfg_out,
    output logic                        conv_start,
    output logic                        bus_active
);
    logic [1:0] sync_q;   // [0] clock line, [1] data line
    bus_evt_t   evt;
    eng_state_e eng_state;
    logic [6:0] my_addr;

    assign my_addr = strap_addr(ADDR_BASE, strap_sel);

    i2c_bt_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({sda_in, scl_in}),
        .dout (sync_q)
    );

    i2c_bt_cond u_cond (
        .clk   (clk),
        .rst   (rst),
        .scl_s (sync_q[0]),
        .sda_s (sync_q[1]),
        .evt   (evt)
    );

    i2c_bt_engine #(.CFG_BYTES(CFG_BYTES), .RES_BYTES(RES_BYTES)) u_eng (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt),
        .my_addr    (my_addr),
        .busy       (busy),
        .result_in  (result_in),
        .sda_pull   (sda_pull),
        .cfg_out    (cfg_out),
        .conv_start (conv_start),
        .bus_active (bus_active),
        .state      (eng_state)
    );
endmodule

// File: rtl/i2c_bt_checker.sv
module i2c_bt_checker
    import i2c_bt_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       scl_s,
    input logic       busy,
    input logic       sda_pull,
    input logic       bus_active,
    input logic       conv_start,
    input logic       start_evt,
    input eng_state_e state
);
    p_start_active_r1: assert property (@(posedge clk) disable iff (rst)
        start_evt |=> bus_active);

    p_busy_nak_r3: assert property (@(posedge clk) disable iff (rst)
        ($past(state) == ST_ADDR && state == ST_AACK) |-> !$past(busy));

    p_conv_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start);

    p_conv_after_stop_r8: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> !bus_active);

    p_pull_scl_low_r9: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_pull) |-> !$past(scl_s));

    p_idle_release_r9: assert property (@(posedge clk) disable iff (rst)
        !bus_active |-> !sda_pull);
endmodule

bind i2c_busy_target i2c_bt_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .scl_s      (sync_q[0]),
    .busy       (busy),
    .sda_pull   (sda_pull),
    .bus_active (bus_active),
    .conv_start (conv_start),
    .start_evt  (evt.start),
    .state      (eng_state)
);

// File: tb/i2c_busy_target_bench.sv
module i2c_busy_target_bench;
    localparam int Q = 10;
    localparam logic [6:0] BASE = 7'h24;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl = 1'b1;
    logic        m_sda = 1'b1;
    logic        sda_line;
    logic        sda_pull;
    logic [3:0]  strap_sel = 4'd0;
    logic        busy = 1'b0;
    logic [23:0] result_in = 24'hC35A96;
    logic [15:0] cfg_out;
    logic        conv_start;
    logic        bus_active;

    int n_chk = 0;
    int n_bad = 0;
    int conv_cnt = 0;
    int cyc = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    assign sda_line = m_sda & ~sda_pull;

    i2c_busy_target u_i2c_busy_target (
        .clk        (clk),
        .rst        (rst),
        .scl_in     (scl),
        .sda_in     (sda_line),
        .sda_pull   (sda_pull),
        .strap_sel  (strap_sel),
        .busy       (busy),
        .result_in  (result_in),
        .cfg_out    (cfg_out),
        .conv_start (conv_start),
        .bus_active (bus_active)
    );

    always @(negedge clk) if (conv_start) conv_cnt++;

    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog act=%0d cycles exp=finish", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    // {strap[3:0], busy, addr[6:0], expected_ack}
    localparam logic [12:0] VEC [8] = '{
        {4'd0,  1'b0, 7'h24, 1'b1},
        {4'd8,  1'b0, 7'h2C, 1'b1},
        {4'd3,  1'b0, 7'h27, 1'b1},
        {4'd3,  1'b0, 7'h28, 1'b0},
        {4'd5,  1'b1, 7'h29, 1'b0},
        {4'd12, 1'b0, 7'h2C, 1'b1},
        {4'd4,  1'b0, 7'h24, 1'b0},
        {4'd0,  1'b1, 7'h24, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wq(input int n = 1);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq();
        scl = 1'b1;   wq();
        m_sda = 1'b0; wq();
        scl = 1'b0;   wq();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq();
        scl = 1'b1;   wq();
        m_sda = 1'b1; wq();
    endtask

    task automatic send_bit(input logic b);
        m_sda = b; wq();
        scl = 1'b1; wq(2);
        scl = 1'b0; wq();
    endtask

    task automatic write_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        m_sda = 1'b1; wq();
        scl = 1'b1;   wq();
        acked = !sda_line;
        wq();
        scl = 1'b0;   wq();
    endtask

    task automatic read_byte(input logic give_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            m_sda = 1'b1; wq();
            scl = 1'b1;   wq();
            b[i] = sda_line;
            wq();
            scl = 1'b0;   wq();
        end
        send_bit(!give_ack);
        m_sda = 1'b1;
    endtask

    initial begin
        logic        ack;
        logic [7:0]  rb;
        logic [15:0] exp_cfg;
        int          c0;

        repeat (5) @(negedge clk);
        chk("R9 reset sda_pull", 32'(sda_pull), 0);
        chk("R9 reset cfg_out", 32'(cfg_out), 0);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        chk("R9 idle sda_pull", 32'(sda_pull), 0);
        chk("R1 idle bus_active", 32'(bus_active), 0);
        chk("R8 idle conv_start", 32'(conv_start), 0);
        exp_cfg = 16'h0000;

        // Vector table: address match, strap clamp, busy refusal, writes
        for (int i = 0; i < 8; i++) begin
            strap_sel = VEC[i][12:9];
            busy      = VEC[i][8];
            c0        = conv_cnt;
            bus_start();
            chk("R1 bus_active after start", 32'(bus_active), 1);
            write_byte({VEC[i][7:1], 1'b0}, ack);
            chk("R2/R3/R4 address ack", 32'(ack), 32'(VEC[i][0]));
            if (ack) begin
                write_byte(8'h30 + 8'(i), ack);
                chk("R5 data ack", 32'(ack), 1);
                exp_cfg[15:8] = 8'h30 + 8'(i);
            end else begin
                write_byte(8'h30 + 8'(i), ack);
                chk("R3/R4 ignored data no ack", 32'(ack), 0);
            end
            bus_stop();
            wq();
            chk("R5 cfg_out", 32'(cfg_out), 32'(exp_cfg));
            chk("R8 conv pulses", 32'(conv_cnt - c0), 32'(VEC[i][0]));
            chk("R1 bus_active after stop", 32'(bus_active), 0);
        end
        busy = 1'b0;
        strap_sel = 4'd0;

        // R5: two bytes fill cfg, third refused
        c0 = conv_cnt;
        bus_start();
        write_byte({BASE, 1'b0}, ack);
        write_byte(8'hA1, ack); chk("R5 byte0 ack", 32'(ack), 1);
        write_byte(8'h5E, ack); chk("R5 byte1 ack", 32'(ack), 1);
        write_byte(8'hFF, ack); chk("R5 overflow nak", 32'(ack), 0);
        bus_stop(); wq();
        chk("R5 cfg two bytes", 32'(cfg_out), 32'h0000A15E);
        chk("R8 one pulse", 32'(conv_cnt - c0), 1);

        // R6: read with wrap, then NAK and released line
        c0 = conv_cnt;
        bus_start();
        write_byte({BASE, 1'b1}, ack); chk("R6 read addr ack", 32'(ack), 1);
        read_byte(1'b1, rb); chk("R6 byte0", 32'(rb), 32'hC3);
        read_byte(1'b1, rb); chk("R6 byte1", 32'(rb), 32'h5A);
        read_byte(1'b1, rb); chk("R6 byte2", 32'(rb), 32'h96);
        read_byte(1'b0, rb); chk("R6 wrap byte0", 32'(rb), 32'hC3);
        read_byte(1'b0, rb); chk("R6 released after nak", 32'(rb), 32'hFF);
        bus_stop(); wq();
        chk("R8 no pulse on read", 32'(conv_cnt - c0), 0);
        chk("R5 cfg kept by read", 32'(cfg_out), 32'h0000A15E);

        // R7: repeated start mid-byte, then read
        c0 = conv_cnt;
        bus_start();
        write_byte({BASE, 1'b0}, ack);
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        bus_start();
        chk("R7 bus_active across Sr", 32'(bus_active), 1);
        write_byte({BASE, 1'b1}, ack); chk("R7 address after Sr", 32'(ack), 1);
        read_byte(1'b0, rb); chk("R7 read after Sr", 32'(rb), 32'hC3);
        bus_stop(); wq();
        chk("R8 no pulse for partial byte", 32'(conv_cnt - c0), 0);
        chk("R7 cfg untouched by partial byte", 32'(cfg_out), 32'h0000A15E);

        // R3: busy refusal on read keeps the line released
        busy = 1'b1;
        bus_start();
        write_byte({BASE, 1'b1}, ack); chk("R3 busy read nak", 32'(ack), 0);
        read_byte(1'b0, rb); chk("R3 nothing driven", 32'(rb), 32'hFF);
        bus_stop(); wq();
        busy = 1'b0;

        // R8: address-only write gives no pulse
        c0 = conv_cnt;
        bus_start();
        write_byte({BASE, 1'b0}, ack); chk("R2 addr ack", 32'(ack), 1);
        bus_stop(); wq();
        chk("R8 no pulse address only", 32'(conv_cnt - c0), 0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule